// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A one-cycle start strobe loads the first column, a burst length code and an ordering select. From the next clock onward the block presents one column per cycle, together with a valid flag and a flag marking the final beat. The command decoder that drives it handles banks, rows, CAS latency and data masking. This block only sequences columns.

Two orderings are offered. In sequential order the beat count is added to the low column bits inside an aligned block of the burst length, and the sum wraps inside that block. In interleaved order the low bits are the starting low bits XORed with the beat count. A full-page length counts straight up through the page and wraps at the page edge. It has no natural end, so only a terminate strobe or a new start stops it. A new start is accepted on any clock. It discards the beats still pending and begins a complete new burst.

The sequencer has three states: `S_IDLE`, `S_BURST` (finite burst) and `S_PAGE` (full-page run). Its transitions are:
- **launch**: from any state to `S_BURST` or `S_PAGE` on a valid start.
- **reject**: from any state to `S_IDLE` on a start with an unsupported setting.
- **stop**: from `S_BURST` or `S_PAGE` to `S_IDLE` on terminate when no start is present.
- **finish**: from `S_BURST` to `S_IDLE` after the last beat.
- **step**: a state stays where it is and its beat counter advances.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o`, `last_o` and `err_o` are low.
- R2: A valid start makes `valid_o` high in the next cycle, and `col_o` then equals the start column in every mode.
- R3: Sequential order (`btype_i`=0) with lengths 2, 4 or 8 outputs the low bits as (start low bits + beat) modulo the length. Length 4 from low bits 2 gives 2,3,0,1.
- R4: Interleaved order (`btype_i`=1) outputs the low bits as the start low bits XOR the beat number. Length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: A finite burst of length N gives exactly N valid beats. The column bits above the low log2(N) bits never change during the burst. `last_o` is high only on beat N, and `valid_o` is low in the cycle after it when no start arrives.
- R6: Length code 0 (one beat) gives a single valid beat with `last_o` high.
- R7: Length code 7 (full page, sequential only) outputs start, start+1, start+2 and so on, modulo PAGE_COLS (default 512). `last_o` never goes high, and the run continues until terminate or a start arrives.
- R8: A start during an active burst drops the remaining beats. The next cycle shows the new start column, and the new burst runs its full length.
- R9: Terminate without start makes `valid_o` low in the next cycle. When start and terminate arrive in the same cycle, the start wins.
- R10: A start with length code 7 and interleaved order, or with a length code of 4, 5 or 6, raises `err_o` for exactly one cycle in the next cycle. It issues no beats and cancels any burst in progress.
- R11: Length code and ordering are sampled only on the start strobe. Changes to `blen_i` or `btype_i` during a burst do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new burst |
| col_i | input | COL_W (9) | Starting column |
| blen_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=full page, 4..6 invalid |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W (9) | Column for the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | Previous start had an unsupported setting |

## Verification
Every result appears exactly one clock after the edge that samples its cause:
- A start shows its first column, or its error pulse, one cycle later.
- Each following beat advances once per edge.
- A terminate or a finished burst clears `valid_o` one edge later.

The bench drives inputs on the falling edge and samples shortly after the next rising edge. A bench-side model, stepped on that same edge, is compared with the outputs every cycle. Directed sequences with literal expected columns cover the documented orders, page wrap, restart and the error case. Seeded random traffic then mixes starts, terminates and input changes in the middle of a burst.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BURST = 2'd1,
        S_PAGE  = 2'd2
    } bst_state_t;

    localparam logic [2:0] BLEN_FULL = 3'd7;

    // beats minus one for the finite length codes; zero for other codes
    function automatic logic [2:0] beats_m1(input logic [2:0] code);
        unique case (code)
            3'd0:    beats_m1 = 3'd0;
            3'd1:    beats_m1 = 3'd1;
            3'd2:    beats_m1 = 3'd3;
            3'd3:    beats_m1 = 3'd7;
            default: beats_m1 = 3'd0;
        endcase
    endfunction

    function automatic logic setting_bad(input logic [2:0] code, input logic ilv);
        setting_bad = (code inside {3'd4, 3'd5, 3'd6}) || (code == BLEN_FULL && ilv);
    endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       blen_i,
    input  logic             btype_i,
    input  logic             term_i,
    output bst_state_t       state_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [2:0]       blen_o,
    output logic             btype_o,
    output logic             last_o,
    output logic             err_o
);

    bst_state_t       state_q, state_d;
    logic [COL_W-1:0] cnt_q, cnt_d;
    logic [COL_W-1:0] base_q;
    logic [2:0]       blen_q;
    logic             btype_q;
    logic             err_q;
    logic             bad_start;
    logic             at_end;

    assign bad_start = start_i && setting_bad(blen_i, btype_i);
    assign at_end    = (cnt_q == {{(COL_W-3){1'b0}}, beats_m1(blen_q)});

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start_i) begin
            cnt_d = '0;
            if (bad_start)                state_d = S_IDLE;
            else if (blen_i == BLEN_FULL) state_d = S_PAGE;
            else                          state_d = S_BURST;
        end else if (term_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_BURST: begin
                    if (at_end) state_d = S_IDLE;
                    else        cnt_d   = cnt_q + 1'b1;
                end
                S_PAGE:  cnt_d = cnt_q + 1'b1;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            blen_q  <= '0;
            btype_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= bad_start;
            if (start_i && !bad_start) begin
                base_q  <= col_i;
                blen_q  <= blen_i;
                btype_q <= btype_i;
            end
        end
    end

    always_comb begin
        state_o = state_q;
        base_o  = base_q;
        cnt_o   = cnt_q;
        blen_o  = blen_q;
        btype_o = btype_q;
        err_o   = err_q;
        last_o  = (state_q == S_BURST) && at_end;
    end

    // R2: a good start always leads to an active state
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !setting_bad(blen_i, btype_i)) |=> (state_o != S_IDLE));
    // R9: terminate alone ends the burst
    p_term_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> (state_o == S_IDLE));
    // R10: a bad start gives an error pulse and no beat
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && setting_bad(blen_i, btype_i)) |=> (err_o && state_o == S_IDLE));
    // R5: nothing follows the last beat without a new start
    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> (state_o == S_IDLE));
    // R7: a full-page run never flags a last beat
    p_page_nolast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_PAGE) |-> !last_o);

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [2:0]       blen_i,
    input  logic             btype_i,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] summed;
    logic [COL_W-1:0] mixed;

    always_comb begin
        if (blen_i == BLEN_FULL) mask_o = '1;
        else                     mask_o = {{(COL_W-3){1'b0}}, beats_m1(blen_i)};
        summed = base_i + cnt_i;
        mixed  = btype_i ? (base_i ^ cnt_i) : summed;
        col_o  = (base_i & ~mask_o) | (mixed & mask_o);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_burst_pkg::*;
#(
    parameter int PAGE_COLS = 512,
    localparam int COL_W    = $clog2(PAGE_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       blen_i,
    input  logic             btype_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    bst_state_t       state;
    logic [COL_W-1:0] base, cnt, mask;
    logic [2:0]       blen_q;
    logic             btype_q;

    burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .col_i   (col_i),
        .blen_i  (blen_i),
        .btype_i (btype_i),
        .term_i  (term_i),
        .state_o (state),
        .base_o  (base),
        .cnt_o   (cnt),
        .blen_o  (blen_q),
        .btype_o (btype_q),
        .last_o  (last_o),
        .err_o   (err_o)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base_i  (base),
        .cnt_i   (cnt),
        .blen_i  (blen_q),
        .btype_i (btype_q),
        .mask_o  (mask),
        .col_o   (col_o)
    );

    assign valid_o = (state != S_IDLE);

    // R5: upper column bits hold through a finite burst
    p_high_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BURST && !last_o && !start_i && !term_i)
        |=> ((col_o & ~mask) == $past(col_o & ~mask)));
    // R7: full page steps by one, wrapping at the page edge
    p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAGE && !start_i && !term_i) |=> (col_o == $past(col_o) + 1'b1));
    // R8: restart shows the new start column immediately
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !setting_bad(blen_i, btype_i)) |=> (col_o == $past(col_i)));
    // R6: last only on a valid beat
    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

endmodule

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;

    localparam int PAGE = 512;
    localparam int CW   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] col_i = '0;
    logic [2:0]    blen_i = '0;
    logic          btype_i = 1'b0;
    logic          term_i = 1'b0;
    logic [CW-1:0] col_o;
    logic          valid_o, last_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen #(.PAGE_COLS(PAGE)) u_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .blen_i(blen_i), .btype_i(btype_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    // reference model state
    bit m_act, m_page, m_type, m_err;
    int m_base, m_cnt, m_len;

    function automatic int len_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit bad_of(input int code, input bit ilv);
        return (code >= 4 && code <= 6) || (code == 7 && ilv);
    endfunction

    function automatic int exp_col(input int base, input int cnt, input int len,
                                   input bit page, input bit ilv);
        int lo;
        if (page) return (base + cnt) % PAGE;
        lo = base % len;
        if (ilv) lo = lo ^ cnt;
        else     lo = (lo + cnt) % len;
        return base - (base % len) + lo;
    endfunction

    task automatic model_edge();
        m_err = 1'b0;
        if (start_i) begin
            if (bad_of(int'(blen_i), btype_i)) begin
                m_err = 1'b1;
                m_act = 1'b0;
            end else begin
                m_act  = 1'b1;
                m_page = (blen_i == 3'd7);
                m_len  = len_of(int'(blen_i));
                m_type = btype_i;
                m_base = int'(col_i);
                m_cnt  = 0;
            end
        end else if (term_i) begin
            m_act = 1'b0;
        end else if (m_act) begin
            if (!m_page && m_cnt == m_len - 1) m_act = 1'b0;
            else m_cnt = m_cnt + 1;
        end
    endtask

    task automatic model_check();
        bit ev, el;
        int ec;
        ev = m_act;
        el = m_act && !m_page && (m_cnt == m_len - 1);
        ec = m_act ? exp_col(m_base, m_cnt, m_len, m_page, m_type) : 0;
        n_chk++;
        if (valid_o !== ev || last_o !== el || err_o !== m_err ||
            (ev && col_o !== CW'(ec))) begin
            n_bad++;
            $display("FAIL model(R2-R11 ordering): got v=%0b l=%0b e=%0b col=%0h exp v=%0b l=%0b e=%0b col=%0h",
                     valid_o, last_o, err_o, col_o, ev, el, m_err, ec);
        end
    endtask

    task automatic chk(input string req, input bit ev, input int ec, input bit el);
        n_chk++;
        if (valid_o !== ev || last_o !== el || (ev && col_o !== CW'(ec))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b l=%0b col=%0h exp v=%0b l=%0b col=%0h",
                     req, valid_o, last_o, col_o, ev, el, ec);
        end
    endtask

    task automatic chk_err(input string req, input bit ee);
        n_chk++;
        if (err_o !== ee) begin
            n_bad++;
            $display("FAIL %s: err got %0b exp %0b", req, err_o, ee);
        end
    endtask

    task automatic step(input bit st, input int c, input int bl, input bit bt, input bit tm);
        @(negedge clk);
        start_i = st; col_i = CW'(c); blen_i = 3'(bl); btype_i = bt; term_i = tm;
        @(posedge clk);
        model_edge();
        #1;
        model_check();
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run hung, got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 1'b0, 0, 1'b0);
        chk_err("R1 in reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after reset", 1'b0, 0, 1'b0);
        chk_err("R1 after reset", 1'b0);

        // R3 sequential length 4 from low bits 2; R2 first beat is start column
        step(1'b1, 'h0A6, 2, 1'b0, 1'b0);
        chk("R2 first beat", 1'b1, 'h0A6, 1'b0);
        idle(); chk("R3 seq4 beat1", 1'b1, 'h0A7, 1'b0);
        idle(); chk("R3 seq4 beat2", 1'b1, 'h0A4, 1'b0);
        idle(); chk("R5 seq4 last",  1'b1, 'h0A5, 1'b1);
        idle(); chk("R5 after last", 1'b0, 0, 1'b0);

        // R4 interleaved length 8 from 5
        step(1'b1, 'h1F5, 3, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R4 ilv8", 1'b1, 'h1F0 | (5 ^ i), i == 7);
            // R11: wiggle length/type during the burst
            step(1'b0, 0, i % 8, i[0], 1'b0);
        end
        chk("R11 held settings", 1'b0, 0, 1'b0);

        // R6 single beat
        step(1'b1, 'h033, 0, 1'b0, 1'b0);
        chk("R6 single", 1'b1, 'h033, 1'b1);
        idle(); chk("R6 single end", 1'b0, 0, 1'b0);

        // R7 full page wrap, then R9 terminate
        step(1'b1, 'h1FE, 7, 1'b0, 1'b0);
        chk("R7 page0", 1'b1, 'h1FE, 1'b0);
        idle(); chk("R7 page1", 1'b1, 'h1FF, 1'b0);
        idle(); chk("R7 page wrap", 1'b1, 'h000, 1'b0);
        idle(); chk("R7 page3", 1'b1, 'h001, 1'b0);
        step(1'b0, 0, 0, 1'b0, 1'b1);
        chk("R9 terminate", 1'b0, 0, 1'b0);

        // R8 restart in mid burst, with terminate in the same cycle (R9)
        step(1'b1, 'h010, 3, 1'b0, 1'b0);
        idle();
        step(1'b1, 'h041, 1, 1'b0, 1'b1);
        chk("R8 restart", 1'b1, 'h041, 1'b0);
        idle(); chk("R8 full new burst", 1'b1, 'h040, 1'b1);

        // R10 invalid setting cancels a running burst
        step(1'b1, 'h100, 7, 1'b0, 1'b0);
        step(1'b1, 'h020, 7, 1'b1, 1'b0);
        chk("R10 no beat", 1'b0, 0, 1'b0);
        chk_err("R10 err pulse", 1'b1);
        idle(); chk_err("R10 err one cycle", 1'b0);
        step(1'b1, 'h020, 5, 1'b0, 1'b0);
        chk_err("R10 reserved code", 1'b1);

        // seeded random traffic
        for (int k = 0; k < 4000; k++) begin
            bit st, tm;
            st = ($urandom % 6) == 0;
            tm = ($urandom % 20) == 0;
            step(st, int'($urandom % PAGE), int'($urandom % 8), 1'($urandom), tm);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule